// File: doc/BRIEF.md
# Crossbar Training Sequence Controller

This controller runs the iterative training loop for an associative memory held in a pair of analog crossbar arrays. When it is started, it captures a set of binary prototype patterns and asks once for both weight arrays to be initialised. It then repeats a fixed cycle. It draws a pattern that has not yet passed, presents it to an external recall stage, and turns that stage's per-column comparator flags into a 2-bit correction code per column. If any column is in error, it steps through the columns one at a time and issues programming pulses.

A counter holds the number of consecutive error-free recalls. A pattern that recalls cleanly adds one to the count and leaves the arrays untouched. Any error clears the count and makes every pattern eligible again. Training ends with a done flag once every pattern has recalled cleanly in one unbroken run. A run-time limit on the number of presentations ends a run that does not converge with a timeout flag instead. The analog arrays, comparators and pulse drivers sit outside the block, and all exchanges with them use request/acknowledge handshakes.

Top module: `xbar_train_ctrl`

## Requirements
- R1: After synchronous reset, `init_req_o`, `recall_req_o`, `prog_req_o`, `done_o` and `timeout_o` are low and `pass_cnt_o` is 0. At most one of the three request outputs is high in any cycle.
- R2: A `start_i` pulse from idle or from a finished run raises `init_req_o` and holds it until `init_ack_i`. No recall request is made before that acknowledge.
- R3: On start the block captures `pat_bits_i`, where bit `p*NCOL+j` is element j of pattern p and a 1 stands for +1. While `recall_req_o` is high, `recall_sign_o` equals the selected pattern and `sel_idx_o` names it, and both hold until `recall_valid_i`.
- R4: A selected pattern is never one that has already passed in the current unbroken run.
- R5: Column j is judged from four thermometer flags (`cmp_hh_i` above the high level plus tolerance, `cmp_hl_i` above the high level minus tolerance, `cmp_lh_i` above the low level plus tolerance, `cmp_ll_i` above the low level minus tolerance). Expected +1 is correct when hl is set and hh is clear. Expected −1 is correct when ll is set and lh is clear. Output above the band gives code 2'b10 (push negative), output below it gives 2'b01 (push positive), and a correct column gives 2'b00.
- R6: A presentation with every column correct raises `pass_cnt_o` by one and issues no programming command.
- R7: A presentation with any column in error sets `pass_cnt_o` to 0 and makes every pattern eligible again. It then issues one programming command for each erroneous column, in ascending column order. Each command shows `prog_col_o`, with `prog_pol_o` = 1 for push positive, and holds until `prog_ack_i`. Correct columns get no command.
- R8: When `pass_cnt_o` reaches NPAT, `done_o` rises and stays high, and no further request is made.
- R9: When `iter_limit_i` (captured at start, 0 = no limit) is non-zero and that many presentations have been made without finishing, `timeout_o` rises, `done_o` stays low and no further request is made.
- R10: A `start_i` pulse after done or timeout clears the pass count and both end flags and begins again with initialisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a training run |
| pat_bits_i | input | NPAT*NCOL | Prototype patterns, captured at start |
| iter_limit_i | input | ITW | Presentation limit, 0 = none, captured at start |
| init_req_o | output | 1 | Request initialisation of both arrays |
| init_ack_i | input | 1 | Initialisation finished |
| recall_req_o | output | 1 | Request a recall of the presented pattern |
| recall_sign_o | output | NCOL | Drive sign per element, 1 = positive level |
| sel_idx_o | output | IDXW | Index of the presented pattern |
| recall_valid_i | input | 1 | Comparator flags are valid |
| cmp_hh_i | input | NCOL | Output above high level plus tolerance |
| cmp_hl_i | input | NCOL | Output above high level minus tolerance |
| cmp_lh_i | input | NCOL | Output above low level plus tolerance |
| cmp_ll_i | input | NCOL | Output above low level minus tolerance |
| prog_req_o | output | 1 | Programming pulse request for one column |
| prog_col_o | output | COLW | Column to program |
| prog_pol_o | output | 1 | 1 = push positive, 0 = push negative |
| prog_ack_i | input | 1 | Programming pulse finished |
| pass_cnt_o | output | CNTW | Consecutive error-free recalls |
| done_o | output | 1 | Training converged |
| timeout_o | output | 1 | Presentation limit reached |

## Verification
A stale eligibility mask shows up at the next `recall_req_o` as a repeated `sel_idx_o` inside one run, or as a pass count that disagrees with the number of distinct patterns presented. A miscoded comparator flag appears within a few cycles of `recall_valid_i`: a wrong column, a wrong polarity, or a missing or extra programming command. A wrong pass counter or iteration counter shows in the number of presentations before `done_o` or `timeout_o`. The bench checks that count against its own running model.

// File: rtl/xbar_train_pkg.sv
package xbar_train_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_SELECT, ST_RECALL,
    ST_DETECT, ST_PROGRAM, ST_CHECK, ST_DONE
  } train_state_e;

  localparam logic [1:0] DIFF_OK = 2'b00;
  localparam logic [1:0] DIFF_UP = 2'b01;
  localparam logic [1:0] DIFF_DN = 2'b10;

  // Correction code for one column from its thermometer flags.
  function automatic logic [1:0] judge_col(input logic pos, input logic hh,
                                           input logic hl, input logic lh,
                                           input logic ll);
    logic too_hi, too_lo;
    too_hi = pos ? hh : lh;
    too_lo = pos ? !hl : !ll;
    if (too_hi) return DIFF_DN;
    if (too_lo) return DIFF_UP;
    return DIFF_OK;
  endfunction

  // One step of a 16-bit Galois shift register.
  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
  endfunction

endpackage

// File: rtl/xbar_lfsr16.sv
module xbar_lfsr16 import xbar_train_pkg::*; #(
  parameter int          OUTW = 2,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [OUTW-1:0] rnd_o
);
  logic [15:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else     state_q <= lfsr_next(state_q);
  end

  assign rnd_o = state_q[OUTW-1:0];
endmodule

// File: rtl/xbar_col_judge.sv
module xbar_col_judge import xbar_train_pkg::*; (
  input  logic       sign_i,
  input  logic       hh_i,
  input  logic       hl_i,
  input  logic       lh_i,
  input  logic       ll_i,
  output logic [1:0] code_o
);
  assign code_o = judge_col(sign_i, hh_i, hl_i, lh_i, ll_i);
endmodule

// File: rtl/xbar_pick.sv
module xbar_pick #(
  parameter int NPAT = 4,
  parameter int IDXW = 2
) (
  input  logic [IDXW-1:0] rnd_i,
  input  logic [NPAT-1:0] mask_i,
  output logic            ok_o
);
  localparam int PADN = 1 << IDXW;

  logic [PADN-1:0] blocked;

  // Indices past the last pattern count as blocked (rejection sampling).
  assign blocked = PADN'(mask_i) | ~PADN'({NPAT{1'b1}});
  assign ok_o    = !blocked[rnd_i];
endmodule

// File: rtl/xbar_train_ctrl.sv
module xbar_train_ctrl import xbar_train_pkg::*; #(
  parameter int          NPAT = 4,
  parameter int          NCOL = 4,
  parameter int          ITW  = 16,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int         IDXW = $clog2(NPAT),
  localparam int         COLW = $clog2(NCOL),
  localparam int         CNTW = $clog2(NPAT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [NPAT*NCOL-1:0] pat_bits_i,
  input  logic [ITW-1:0]       iter_limit_i,
  output logic                 init_req_o,
  input  logic                 init_ack_i,
  output logic                 recall_req_o,
  output logic [NCOL-1:0]      recall_sign_o,
  output logic [IDXW-1:0]      sel_idx_o,
  input  logic                 recall_valid_i,
  input  logic [NCOL-1:0]      cmp_hh_i,
  input  logic [NCOL-1:0]      cmp_hl_i,
  input  logic [NCOL-1:0]      cmp_lh_i,
  input  logic [NCOL-1:0]      cmp_ll_i,
  output logic                 prog_req_o,
  output logic [COLW-1:0]      prog_col_o,
  output logic                 prog_pol_o,
  input  logic                 prog_ack_i,
  output logic [CNTW-1:0]      pass_cnt_o,
  output logic                 done_o,
  output logic                 timeout_o
);

  train_state_e                    state_q;
  logic [NPAT-1:0][NCOL-1:0]       pats_q;
  logic [ITW-1:0]                  limit_q, iter_q;
  logic [IDXW-1:0]                 sel_q;
  logic [NCOL-1:0][1:0]            diff_q, diff_w;
  logic [COLW-1:0]                 col_q;
  logic [CNTW-1:0]                 st_q;
  logic [NPAT-1:0]                 mask_q;
  logic                            tmo_q;

  logic [IDXW-1:0] rnd;
  logic            pick_ok;
  logic [NCOL-1:0] cur_sign;
  logic [1:0]      cur_code;
  logic            any_err, col_step;

  // Named events, also used by the checker
  logic ev_pass, ev_fail, ev_start;

  xbar_lfsr16 #(.OUTW(IDXW), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst(rst), .rnd_o(rnd)
  );

  xbar_pick #(.NPAT(NPAT), .IDXW(IDXW)) u_pick (
    .rnd_i(rnd), .mask_i(mask_q), .ok_o(pick_ok)
  );

  assign cur_sign = pats_q[sel_q];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    xbar_col_judge u_judge (
      .sign_i(cur_sign[c]), .hh_i(cmp_hh_i[c]), .hl_i(cmp_hl_i[c]),
      .lh_i(cmp_lh_i[c]),   .ll_i(cmp_ll_i[c]), .code_o(diff_w[c])
    );
  end

  assign any_err  = |diff_q;
  assign ev_pass  = (state_q == ST_DETECT) && !any_err;
  assign ev_fail  = (state_q == ST_DETECT) && any_err;
  assign ev_start = ((state_q == ST_IDLE) || (state_q == ST_DONE)) && start_i;
  assign cur_code = diff_q[col_q];
  assign col_step = (cur_code == DIFF_OK) || prog_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pats_q  <= '0;
      limit_q <= '0;
      iter_q  <= '0;
      sel_q   <= '0;
      diff_q  <= '0;
      col_q   <= '0;
      st_q    <= '0;
      mask_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (ev_start) begin
          pats_q  <= pat_bits_i;
          limit_q <= iter_limit_i;
          iter_q  <= '0;
          st_q    <= '0;
          mask_q  <= '0;
          tmo_q   <= 1'b0;
          state_q <= ST_INIT;
        end
        ST_INIT: if (init_ack_i) state_q <= ST_SELECT;
        ST_SELECT: if (pick_ok) begin
          sel_q   <= rnd;
          state_q <= ST_RECALL;
        end
        ST_RECALL: if (recall_valid_i) begin
          diff_q  <= diff_w;
          state_q <= ST_DETECT;
        end
        ST_DETECT: begin
          iter_q <= iter_q + ITW'(1);
          col_q  <= '0;
          if (ev_fail) begin
            st_q    <= '0;
            mask_q  <= '0;
            state_q <= ST_PROGRAM;
          end else begin
            st_q          <= st_q + CNTW'(1);
            mask_q[sel_q] <= 1'b1;
            state_q       <= ST_CHECK;
          end
        end
        ST_PROGRAM: if (col_step) begin
          if (col_q == COLW'(NCOL - 1)) state_q <= ST_CHECK;
          else                          col_q   <= col_q + COLW'(1);
        end
        ST_CHECK: begin
          if (st_q == CNTW'(NPAT)) state_q <= ST_DONE;
          else if ((limit_q != '0) && (iter_q == limit_q)) begin
            tmo_q   <= 1'b1;
            state_q <= ST_DONE;
          end else state_q <= ST_SELECT;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign init_req_o    = (state_q == ST_INIT);
  assign recall_req_o  = (state_q == ST_RECALL);
  assign recall_sign_o = cur_sign;
  assign sel_idx_o     = sel_q;
  assign prog_req_o    = (state_q == ST_PROGRAM) && (cur_code != DIFF_OK);
  assign prog_col_o    = col_q;
  assign prog_pol_o    = (cur_code == DIFF_UP);
  assign pass_cnt_o    = st_q;
  assign done_o        = (state_q == ST_DONE) && !tmo_q;
  assign timeout_o     = tmo_q;

endmodule

// File: rtl/xbar_train_chk.sv
module xbar_train_chk #(
  parameter int NPAT = 4,
  parameter int NCOL = 4,
  localparam int IDXW = $clog2(NPAT),
  localparam int COLW = $clog2(NCOL),
  localparam int CNTW = $clog2(NPAT + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            init_req_o,
  input logic            recall_req_o,
  input logic            recall_valid_i,
  input logic [NCOL-1:0] recall_sign_o,
  input logic [IDXW-1:0] sel_idx_o,
  input logic            prog_req_o,
  input logic            prog_ack_i,
  input logic [COLW-1:0] prog_col_o,
  input logic            prog_pol_o,
  input logic [CNTW-1:0] pass_cnt_o,
  input logic            done_o,
  input logic            timeout_o,
  input logic [NPAT-1:0] pass_mask,
  input logic            ev_pass,
  input logic            ev_fail
);

  // R1
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({init_req_o, recall_req_o, prog_req_o}));

  // R3
  recall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    recall_req_o && !recall_valid_i |=> recall_req_o && $stable(recall_sign_o) && $stable(sel_idx_o));

  // R4
  sel_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    recall_req_o |-> !pass_mask[sel_idx_o]);

  // R4
  mask_count_chk: assert property (@(posedge clk) disable iff (rst)
    recall_req_o |-> $countones(pass_mask) == int'(pass_cnt_o));

  // R6
  pass_inc_chk: assert property (@(posedge clk) disable iff (rst)
    ev_pass |=> pass_cnt_o == $past(pass_cnt_o) + CNTW'(1));

  // R7
  fail_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ev_fail |=> pass_cnt_o == '0 && pass_mask == '0);

  // R7
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    prog_req_o && !prog_ack_i |=> prog_req_o && $stable(prog_col_o) && $stable(prog_pol_o));

  // R8
  done_full_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pass_cnt_o == CNTW'(NPAT));

  // R9
  end_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && timeout_o));

  // R8
  end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o || timeout_o) |-> !recall_req_o && !prog_req_o && !init_req_o);

endmodule

bind xbar_train_ctrl xbar_train_chk #(.NPAT(NPAT), .NCOL(NCOL)) u_chk (
  .clk(clk), .rst(rst), .init_req_o(init_req_o), .recall_req_o(recall_req_o),
  .recall_valid_i(recall_valid_i), .recall_sign_o(recall_sign_o),
  .sel_idx_o(sel_idx_o), .prog_req_o(prog_req_o), .prog_ack_i(prog_ack_i),
  .prog_col_o(prog_col_o), .prog_pol_o(prog_pol_o), .pass_cnt_o(pass_cnt_o),
  .done_o(done_o), .timeout_o(timeout_o), .pass_mask(mask_q),
  .ev_pass(ev_pass), .ev_fail(ev_fail)
);

// File: tb/xbar_train_ctrl_tb.sv
module xbar_train_ctrl_tb;
  localparam int NPAT = 4;
  localparam int NCOL = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] pat_bits_i = 16'h1F6A;
  logic [15:0] iter_limit_i = '0;
  logic        init_ack_i = 1'b0, recall_valid_i = 1'b0, prog_ack_i = 1'b0;
  logic [3:0]  cmp_hh_i = '0, cmp_hl_i = '0, cmp_lh_i = '0, cmp_ll_i = '0;
  logic        init_req_o, recall_req_o, prog_req_o, prog_pol_o, done_o, timeout_o;
  logic [3:0]  recall_sign_o;
  logic [1:0]  sel_idx_o, prog_col_o;
  logic [2:0]  pass_cnt_o;

  int checks = 0, errors = 0, cyc = 0;
  int exp_st = 0;
  logic [3:0] exp_mask = '0;

  always #4 clk = ~clk;

  xbar_train_ctrl u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .pat_bits_i(pat_bits_i),
    .iter_limit_i(iter_limit_i), .init_req_o(init_req_o), .init_ack_i(init_ack_i),
    .recall_req_o(recall_req_o), .recall_sign_o(recall_sign_o), .sel_idx_o(sel_idx_o),
    .recall_valid_i(recall_valid_i), .cmp_hh_i(cmp_hh_i), .cmp_hl_i(cmp_hl_i),
    .cmp_lh_i(cmp_lh_i), .cmp_ll_i(cmp_ll_i), .prog_req_o(prog_req_o),
    .prog_col_o(prog_col_o), .prog_pol_o(prog_pol_o), .prog_ack_i(prog_ack_i),
    .pass_cnt_o(pass_cnt_o), .done_o(done_o), .timeout_o(timeout_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog R8 act=%0d exp=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Level index 0..4 = number of thermometer flags set; target level 3 for +1, 1 for -1.
  function automatic int level_of(input int mode, input int k, input int j, input bit s);
    int t = s ? 3 : 1;
    case (mode)
      0: return t;
      1: return (k + 2 * j) % 5;
      2: return 0;
      default: return (j == k % 4) ? ((k % 2 == 0) ? 4 : 0) : t;
    endcase
  endfunction

  // 1 = recall request, 2 = done, 3 = timeout, 0 = nothing seen
  task automatic wait_event(output int ev, input string tag);
    ev = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (prog_req_o) check(1'b0, tag, 1, 0);
      if (recall_req_o) begin ev = 1; break; end
      if (done_o) begin ev = 2; break; end
      if (timeout_o) begin ev = 3; break; end
    end
  endtask

  task automatic round(input int mode, input int k);
    int sel, lvl, code, got;
    bit any;
    logic [3:0] pat;
    int codes[4];
    sel = int'(sel_idx_o);
    pat = pat_bits_i[sel*4 +: 4];
    check(recall_sign_o == pat, "R3 sign vector", int'(recall_sign_o), int'(pat));
    check(!exp_mask[sel], "R4 ineligible pick", sel, -1);
    check(int'(pass_cnt_o) == exp_st, "R6 pass count", int'(pass_cnt_o), exp_st);
    any = 1'b0;
    for (int j = 0; j < 4; j++) begin
      int t = pat[j] ? 3 : 1;
      lvl = level_of(mode, k, j, pat[j]);
      cmp_hh_i[j] = (lvl >= 4);
      cmp_hl_i[j] = (lvl >= 3);
      cmp_lh_i[j] = (lvl >= 2);
      cmp_ll_i[j] = (lvl >= 1);
      codes[j] = (lvl == t) ? 0 : (lvl < t ? 1 : 2);
      if (codes[j] != 0) any = 1'b1;
    end
    recall_valid_i = 1'b1;
    @(negedge clk);
    recall_valid_i = 1'b0;
    if (any) begin
      for (int j = 0; j < 4; j++) begin
        if (codes[j] == 0) continue;
        got = 0;
        for (int w = 0; w < 50; w++) begin
          if (prog_req_o) begin got = 1; break; end
          @(negedge clk);
        end
        check(got == 1, "R7 program request", got, 1);
        check(int'(prog_col_o) == j, "R7 column order", int'(prog_col_o), j);
        check(prog_pol_o == (codes[j] == 1), "R5 polarity code", int'(prog_pol_o), int'(codes[j] == 1));
        prog_ack_i = 1'b1;
        @(negedge clk);
        prog_ack_i = 1'b0;
      end
      exp_st = 0;
      exp_mask = '0;
    end else begin
      exp_st++;
      exp_mask[sel] = 1'b1;
    end
  endtask

  task automatic do_start(input logic [15:0] lim);
    iter_limit_i = lim;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(init_req_o == 1'b1, "R2 init request", int'(init_req_o), 1);
    check(int'(pass_cnt_o) == 0, "R10 count cleared", int'(pass_cnt_o), 0);
    check(!done_o && !timeout_o, "R10 flags cleared", int'(done_o) + int'(timeout_o), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(init_req_o && !recall_req_o, "R2 init held", int'(recall_req_o), 0);
    end
    init_ack_i = 1'b1;
    @(negedge clk);
    init_ack_i = 1'b0;
    check(!init_req_o, "R2 single init", int'(init_req_o), 0);
    exp_st = 0;
    exp_mask = '0;
  endtask

  initial begin
    int ev, n;
    repeat (3) @(negedge clk);
    check(!init_req_o && !recall_req_o && !prog_req_o, "R1 reset requests", 1, 0);
    check(!done_o && !timeout_o, "R1 reset flags", int'(done_o), 0);
    check(pass_cnt_o == 0, "R1 reset count", int'(pass_cnt_o), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!init_req_o, "R2 no init without start", int'(init_req_o), 0);

    do_start(16'd0);
    for (int k = 0; k < 30; k++) begin
      wait_event(ev, "R6 unexpected programming");
      check(ev == 1, "R3 recall expected", ev, 1);
      if (ev != 1) break;
      round(1, k);
    end
    for (int k = 0; k < 4; k++) begin
      wait_event(ev, "R6 unexpected programming");
      check(ev == 1, "R3 recall expected", ev, 1);
      if (ev != 1) break;
      round(3, k);
    end
    wait_event(ev, "R6 unexpected programming");
    round(2, 0);
    for (int k = 0; k < 2; k++) begin
      wait_event(ev, "R6 unexpected programming");
      round(0, k);
    end
    wait_event(ev, "R6 unexpected programming");
    round(3, 1);
    check(exp_st == 0, "R7 restart of count", exp_st, 0);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      wait_event(ev, "R6 unexpected programming");
      if (ev != 1) break;
      round(0, k);
      n++;
    end
    check(ev == 2, "R8 done reached", ev, 2);
    check(n == NPAT, "R8 passes to finish", n, NPAT);
    check(int'(pass_cnt_o) == NPAT, "R8 final count", int'(pass_cnt_o), NPAT);
    check(done_o && !timeout_o, "R8 done flag", int'(done_o), 1);
    repeat (5) @(negedge clk);
    check(done_o && !recall_req_o && !init_req_o, "R8 stays done", int'(recall_req_o), 0);

    do_start(16'd5);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      wait_event(ev, "R7 extra programming");
      if (ev != 1) break;
      round(2, k);
      n++;
    end
    check(ev == 3, "R9 timeout reached", ev, 3);
    check(n == 5, "R9 presentations", n, 5);
    check(timeout_o && !done_o, "R9 flags", int'(done_o), 0);
    repeat (5) @(negedge clk);
    check(!recall_req_o && timeout_o, "R9 quiet", int'(recall_req_o), 0);

    do_start(16'd0);
    wait_event(ev, "R6 unexpected programming");
    check(ev == 1, "R10 recall after restart", ev, 1);
    round(0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule